// File: doc/BRIEF.md
# NRZI Packet Framer with Bit Unstuffing

This block sits behind a line sampler that delivers one classified line symbol per bit time. It finds the start of a packet on the idle-to-active transition, turns the NRZI symbol stream into plain bits and drops the stuff bits the transmitter inserted. It also flags stuffing violations and checks the end-of-packet sequence. Each decoded bit leaves as a valid strobe with its value, and every framing event is reported as a single-cycle pulse. Byte assembly and packet checks are done downstream.

The framer also watches the first sixteen decoded bits of each packet. When they form the sync field followed by the low-speed preamble token, it ends the packet, returns to idle and raises a pulse. The line monitor uses that pulse to change the segment to low-speed rate with full-speed polarity.

Top module: `nrzi_framer`

## Requirements
- R1: In idle, a K strobe whose previous strobed symbol was J produces `sop_pulse` and clears both the run-of-ones count and the bit history.
- R2: While receiving, a non-SE0 symbol equal to the previous symbol decodes as bit 1 and a different one decodes as bit 0, shown as `bit_valid` high with `bit_val`.
- R3: After six consecutive output 1 bits, a following 0 raises `stuff_pulse` with `bit_valid` low, and the run-of-ones count is cleared.
- R4: After six consecutive output 1 bits, a following 1 raises `stuff_err` and the framer returns to idle with its previous symbol set to J.
- R5: An SE0 received in place of a data bit produces no output pulse and starts end-of-packet handling.
- R6: During end-of-packet handling, further SE0 symbols give no output, a J gives `eop_pulse` and a return to idle, and a K or SE1 gives `eop_err` and a return to idle.
- R7: In idle, an SE0 strobe becomes the previous symbol, so a K that directly follows it does not start a packet; a J must come first.
- R8: When the first 16 decoded bits of a packet, in arrival order, are 0000000100111100, the 16th bit is output with `pre_pulse` and the framer returns to idle with its previous symbol set to J. The near-miss 0000000100111101 gives no pulse.
- R9: Every output data bit updates the run-of-ones count: a 1 increments it and a 0 clears it. A start of packet also clears it.
- R10: After reset all outputs are low, the framer is idle and the previous symbol is J, so a first strobe of K starts a packet.
- R11: Symbol codes on `sym` are 2'b00 SE0, 2'b01 J, 2'b10 K and 2'b11 SE1. Every output is registered and appears in the clock cycle after the strobe edge. No output is raised in a cycle that follows a clock edge without `sym_valid`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sym_valid | input | 1 | One sampled symbol is present this cycle |
| sym | input | 2 | Symbol code: 00 SE0, 01 J, 10 K, 11 SE1 |
| bit_valid | output | 1 | A decoded data bit is present |
| bit_val | output | 1 | Value of the decoded data bit |
| stuff_pulse | output | 1 | A stuff bit was removed |
| stuff_err | output | 1 | Stuffing violation |
| sop_pulse | output | 1 | Start of packet |
| eop_pulse | output | 1 | Valid end of packet |
| eop_err | output | 1 | Bad end-of-packet sequence |
| pre_pulse | output | 1 | Sync plus preamble seen; request repeater polarity |

## Verification
The bench builds the framer with its default parameters: a run limit of six ones and a 16-bit pattern window holding the sync-plus-preamble value. With these values the bench can reach the exact stuffing boundary, where the sixth 1 is followed by a removed 0 or by a violating 1. It can also reach the sixteenth bit, where the exact pattern matches and the pattern that differs only in its last bit does not. Back-to-back strobes with no gaps test the one-cycle output latency. Gaps between sequences test that no strobe means no output.

// File: rtl/nrzi_framer_pkg.sv
// Package: shared symbol codes and framer states.
// Assumes the sampler has already mapped line pins to these codes.
package nrzi_framer_pkg;
    typedef enum logic [1:0] {
        SYM_SE0 = 2'b00,
        SYM_J   = 2'b01,
        SYM_K   = 2'b10,
        SYM_SE1 = 2'b11
    } line_sym_t;

    typedef enum logic [1:0] {
        FR_IDLE = 2'b00,
        FR_BITS = 2'b01,
        FR_EOP  = 2'b10
    } frame_state_t;
endpackage

// File: rtl/nrzi_run_tracker.sv
// Counts consecutive decoded 1 bits up to RUN_LEN.
// at_limit reports that the next bit must be a stuff bit.
// Assumes clr and inc are never both high.
module nrzi_run_tracker #(
    parameter int RUN_LEN = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic at_limit
);
    localparam int CW = $clog2(RUN_LEN + 1);

    logic [CW-1:0] run_q;

    // Purpose: hold the current run of ones.
    always_ff @(posedge clk) begin
        if (!rst_n)
            run_q <= '0;
        else if (clr)
            run_q <= '0;
        else if (inc && run_q != CW'(RUN_LEN))
            run_q <= run_q + 1'b1;
    end

    // Purpose: flag that the run has reached its limit.
    always_comb at_limit = (run_q == CW'(RUN_LEN));
endmodule

// File: rtl/nrzi_pattern_watch.sv
// Collects the first PAT_LEN decoded bits of a packet, first bit ending in the MSB.
// match is combinational and rises on the shift that completes the pattern.
module nrzi_pattern_watch #(
    parameter int              PAT_LEN = 16,
    parameter logic [PAT_LEN-1:0] PATTERN = 16'b0000000100111100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic shift,
    input  logic din,
    output logic match
);
    localparam int NW = $clog2(PAT_LEN + 1);

    logic [PAT_LEN-1:0] hist_q;
    logic [NW-1:0]      cnt_q;

    // Purpose: record bits until the window is full.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist_q <= '0;
            cnt_q  <= '0;
        end else if (clr) begin
            hist_q <= '0;
            cnt_q  <= '0;
        end else if (shift && cnt_q != NW'(PAT_LEN)) begin
            hist_q <= {hist_q[PAT_LEN-2:0], din};
            cnt_q  <= cnt_q + 1'b1;
        end
    end

    // Purpose: compare the window including the incoming bit.
    always_comb match = shift && (cnt_q == NW'(PAT_LEN - 1))
                        && ({hist_q[PAT_LEN-2:0], din} == PATTERN);
endmodule

// File: rtl/nrzi_framer.sv
// NRZI framer: detects the start of a packet, decodes NRZI, removes stuff bits,
// checks the end-of-packet sequence and spots sync plus preamble.
// Assumes one sym_valid strobe per bit time, already centred by the sampler.
module nrzi_framer
    import nrzi_framer_pkg::*;
#(
    parameter int                 RUN_LEN = 6,
    parameter int                 PAT_LEN = 16,
    parameter logic [PAT_LEN-1:0] PATTERN = 16'b0000000100111100
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sym_valid,
    input  logic [1:0] sym,
    output logic       bit_valid,
    output logic       bit_val,
    output logic       stuff_pulse,
    output logic       stuff_err,
    output logic       sop_pulse,
    output logic       eop_pulse,
    output logic       eop_err,
    output logic       pre_pulse
);
    frame_state_t state_q, state_d;
    line_sym_t    prev_q, cur;
    logic same, bits_ev, sop_ev, data_ev, stuff_ev, serr_ev;
    logic eop_ev, eerr_ev, pre_ev, at_limit, match;

    // Purpose: classify the current strobe into framing events.
    always_comb begin
        cur      = line_sym_t'(sym);
        same     = (cur == prev_q);
        sop_ev   = sym_valid && state_q == FR_IDLE && cur == SYM_K && prev_q == SYM_J;
        bits_ev  = sym_valid && state_q == FR_BITS && cur != SYM_SE0;
        data_ev  = bits_ev && !at_limit;
        stuff_ev = bits_ev && at_limit && !same;
        serr_ev  = bits_ev && at_limit && same;
        pre_ev   = data_ev && match;
        eop_ev   = sym_valid && state_q == FR_EOP && cur == SYM_J;
        eerr_ev  = sym_valid && state_q == FR_EOP && (cur == SYM_K || cur == SYM_SE1);
    end

    // Purpose: choose the next framer state.
    always_comb begin
        state_d = state_q;
        case (state_q)
            FR_IDLE: if (sop_ev) state_d = FR_BITS;
            FR_BITS: begin
                if (sym_valid && cur == SYM_SE0) state_d = FR_EOP;
                else if (serr_ev || pre_ev)      state_d = FR_IDLE;
            end
            FR_EOP:  if (eop_ev || eerr_ev) state_d = FR_IDLE;
            default: state_d = FR_IDLE;
        endcase
    end

    // Purpose: hold state and previous symbol; previous is forced to J on a return to idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= FR_IDLE;
            prev_q  <= SYM_J;
        end else begin
            state_q <= state_d;
            if (sym_valid)
                prev_q <= (state_d == FR_IDLE && state_q != FR_IDLE) ? SYM_J : cur;
        end
    end

    // Purpose: register every output pulse one cycle after its strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_valid   <= 1'b0;
            bit_val     <= 1'b0;
            stuff_pulse <= 1'b0;
            stuff_err   <= 1'b0;
            sop_pulse   <= 1'b0;
            eop_pulse   <= 1'b0;
            eop_err     <= 1'b0;
            pre_pulse   <= 1'b0;
        end else begin
            bit_valid   <= data_ev;
            bit_val     <= data_ev && same;
            stuff_pulse <= stuff_ev;
            stuff_err   <= serr_ev;
            sop_pulse   <= sop_ev;
            eop_pulse   <= eop_ev;
            eop_err     <= eerr_ev;
            pre_pulse   <= pre_ev;
        end
    end

    nrzi_run_tracker #(.RUN_LEN(RUN_LEN)) i_run (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (sop_ev || stuff_ev || serr_ev || (data_ev && !same)),
        .inc      (data_ev && same),
        .at_limit (at_limit)
    );

    nrzi_pattern_watch #(.PAT_LEN(PAT_LEN), .PATTERN(PATTERN)) i_pat (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (sop_ev),
        .shift (bits_ev),
        .din   (same),
        .match (match)
    );
endmodule

// File: rtl/nrzi_framer_chk.sv
// Checker for nrzi_framer: relates output pulses to the strobe that caused them.
module nrzi_framer_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       sym_valid,
    input logic [1:0] sym,
    input logic       bit_valid,
    input logic       bit_val,
    input logic       stuff_pulse,
    input logic       stuff_err,
    input logic       sop_pulse,
    input logic       eop_pulse,
    input logic       eop_err,
    input logic       pre_pulse
);
    assert_out_needs_strobe_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_valid || stuff_pulse || stuff_err || sop_pulse || eop_pulse || eop_err)
        |-> $past(sym_valid));

    assert_one_event_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({bit_valid, stuff_pulse, stuff_err, sop_pulse, eop_pulse, eop_err}));

    assert_sop_on_k_R1: assert property (@(posedge clk) disable iff (!rst_n)
        sop_pulse |-> $past(sym) == 2'b10);

    assert_eop_on_j_R6: assert property (@(posedge clk) disable iff (!rst_n)
        eop_pulse |-> $past(sym) == 2'b01);

    assert_eop_err_sym_R6: assert property (@(posedge clk) disable iff (!rst_n)
        eop_err |-> ($past(sym) == 2'b10 || $past(sym) == 2'b11));

    assert_pre_last_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pre_pulse |-> (bit_valid && !bit_val));

    assert_no_se0_bit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_valid || stuff_pulse || stuff_err) |-> $past(sym) != 2'b00);
endmodule

bind nrzi_framer nrzi_framer_chk i_chk (
    .clk(clk), .rst_n(rst_n), .sym_valid(sym_valid), .sym(sym),
    .bit_valid(bit_valid), .bit_val(bit_val), .stuff_pulse(stuff_pulse),
    .stuff_err(stuff_err), .sop_pulse(sop_pulse), .eop_pulse(eop_pulse),
    .eop_err(eop_err), .pre_pulse(pre_pulse)
);

// File: tb/test_nrzi_framer.sv
module test_nrzi_framer;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sym_valid = 1'b0;
    logic [1:0] sym = 2'b01;
    logic bit_valid, bit_val, stuff_pulse, stuff_err, sop_pulse, eop_pulse, eop_err, pre_pulse;

    localparam logic [1:0] SE0 = 2'b00, J = 2'b01, K = 2'b10, SE1 = 2'b11;
    // expected vector: {bit_valid, bit_val, stuff, stuff_err, sop, eop, eop_err, pre}
    localparam logic [7:0] E_NONE = 8'h00, E_SOP = 8'b0000_1000, E_EOP = 8'b0000_0100,
                           E_EERR = 8'b0000_0010, E_STUFF = 8'b0010_0000,
                           E_SERR = 8'b0001_0000;

    int checks = 0;
    int errors = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];
    logic [1:0] line;
    int         ones;

    always #2.5 clk = ~clk;

    nrzi_framer i_nrzi_framer (
        .clk(clk), .rst_n(rst_n), .sym_valid(sym_valid), .sym(sym),
        .bit_valid(bit_valid), .bit_val(bit_val), .stuff_pulse(stuff_pulse),
        .stuff_err(stuff_err), .sop_pulse(sop_pulse), .eop_pulse(eop_pulse),
        .eop_err(eop_err), .pre_pulse(pre_pulse)
    );

    function automatic logic [7:0] outs();
        return {bit_valid, bit_val, stuff_pulse, stuff_err, sop_pulse, eop_pulse, eop_err, pre_pulse};
    endfunction

    // driver: one strobe, expected result pushed to the scoreboard
    task automatic strobe(input logic [1:0] s, input logic [7:0] e, input string tag);
        @(negedge clk);
        sym_valid = 1'b1;
        sym = s;
        exp_q.push_back(e);
        tag_q.push_back(tag);
    endtask

    task automatic gap();
        @(negedge clk);
        sym_valid = 1'b0;
        @(negedge clk);
    endtask

    task automatic sop(input string tag);
        strobe(J, E_NONE, tag);
        strobe(K, E_SOP, tag);
        line = K;
        ones = 0;
    endtask

    // transmit-side model: NRZI encode one bit and insert a stuff bit after six ones
    task automatic tx_bit(input logic b, input logic pre, input string tag);
        if (!b) line = ~line;
        ones = b ? ones + 1 : 0;
        strobe(line, {1'b1, b, 5'b0, pre}, tag);
        if (ones == 6) begin
            line = ~line;
            ones = 0;
            strobe(line, E_STUFF, "R3");
        end
    endtask

    task automatic tx_bits(input logic [15:0] v, input int n, input logic pre_last, input string tag);
        for (int i = n - 1; i >= 0; i--)
            tx_bit(v[i], pre_last && i == 0, tag);
    endtask

    task automatic eop(input string tag);
        strobe(SE0, E_NONE, "R5");
        strobe(SE0, E_NONE, tag);
        strobe(J, E_EOP, tag);
    endtask

    // monitor: compare each strobe result one cycle later
    always @(posedge clk) begin
        logic v;
        v = sym_valid && rst_n;
        #1;
        if (v) begin
            if (exp_q.size() == 0) begin
                checks++; errors++;
                $display("FAIL R11: output 0x%02h with no expected item", outs());
            end else begin
                logic [7:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                checks++;
                if (outs() !== e) begin
                    errors++;
                    $display("FAIL %s: got 0x%02h expected 0x%02h", t, outs(), e);
                end
            end
        end else if (rst_n && outs() !== 8'h00) begin
            checks++; errors++;
            $display("FAIL R11: got 0x%02h expected 0x00 without strobe", outs());
        end
    end

    initial begin
        fork
            begin
                repeat (3) @(negedge clk);
                rst_n = 1'b1;
                checks++;
                if (outs() !== 8'h00) begin
                    errors++;
                    $display("FAIL R10: reset outputs 0x%02h expected 0x00", outs());
                end
                // R10: previous symbol is J after reset, K starts a packet
                strobe(K, E_SOP, "R10");
                line = K; ones = 0;
                tx_bits(16'h00AB, 8, 1'b0, "R2");
                eop("R6");
                gap();
                // R3/R9: runs of ones with stuffing, mixed data
                sop("R1");
                tx_bits(16'h0001, 8, 1'b0, "R2");
                tx_bits(16'h00FE, 8, 1'b0, "R3");
                tx_bits(16'h003F, 8, 1'b0, "R9");
                tx_bits(16'h00F3, 8, 1'b0, "R2");
                eop("R6");
                gap();
                // R9/R1: ones carried across packets are cleared by SOP
                sop("R1");
                tx_bits(16'h001F, 5, 1'b0, "R9");
                eop("R6");
                sop("R1");
                tx_bits(16'h0002, 2, 1'b0, "R9");
                tx_bits(16'h000F, 4, 1'b0, "R9");
                eop("R6");
                gap();
                // R4: seventh one is a stuffing violation, then idle with J
                sop("R1");
                for (int i = 0; i < 6; i++) strobe(K, 8'b1100_0000, "R2");
                strobe(K, E_SERR, "R4");
                strobe(K, E_SOP, "R4");
                line = K; ones = 0;
                eop("R6");
                gap();
                // R6: EOP errors on K and SE1
                sop("R1");
                tx_bits(16'h0003, 2, 1'b0, "R2");
                strobe(SE0, E_NONE, "R5");
                strobe(K, E_EERR, "R6");
                strobe(K, E_SOP, "R6");
                strobe(SE0, E_NONE, "R5");
                strobe(SE1, E_EERR, "R6");
                gap();
                // R7: SE0 in idle then K does not start a packet
                strobe(SE0, E_NONE, "R7");
                strobe(K, E_NONE, "R7");
                strobe(SE0, E_NONE, "R7");
                strobe(J, E_NONE, "R7");
                strobe(K, E_SOP, "R7");
                line = K; ones = 0;
                eop("R6");
                gap();
                // R8: sync plus preamble
                sop("R1");
                tx_bits(16'b0000000100111100, 16, 1'b1, "R8");
                strobe(K, E_SOP, "R8");
                line = K; ones = 0;
                eop("R6");
                gap();
                // R8: near miss gives no pulse and the packet continues
                sop("R1");
                tx_bits(16'b0000000100111101, 16, 1'b0, "R8");
                tx_bits(16'h0005, 4, 1'b0, "R2");
                eop("R6");
                gap();
                gap();
            end
            begin
                repeat (20000) @(posedge clk);
                checks++; errors++;
                $display("FAIL watchdog: run did not end, expected completion");
            end
        join_any
        disable fork;
        if (exp_q.size() != 0) begin
            checks++; errors++;
            $display("FAIL R11: %0d results missing, expected 0", exp_q.size());
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule